// File: doc/BRIEF.md
# Serial Debug Raw Sequence Shifter

This block moves an arbitrary run of bits, between 0 and 256 long, over the data line of a two-wire serial debug port. It produces the port clock at the shared bit rate, where one bit is a low phase followed by a high phase, each phase lasting a programmable number of system clock cycles. It is used for line resets, protocol-switch patterns and any other raw traffic that does not fit the framed transfer format.

A start pulse sets the direction and the bit count. In transmit mode the block turns the line driver on, pulls bytes from a ready/valid byte stream and sends each byte least significant bit first. In capture mode it releases the line, samples one bit per clock period just before the rising edge, and packs the bits into bytes on a byte output with a valid pulse. Transmit and capture pack bits into bytes in opposite orders: transmit sends bit 0 of a byte first, while capture shifts each new bit in at bit 0. A done pulse marks the end of every sequence, including an empty one.

Top module: `dbg_seq_shifter`

## Requirements
- R1: Out of reset swclk_o is 1, swdio_oe_o, busy_o, done_o, rx_valid_o and tx_ready_o are 0.
- R2: Each bit is one clock period: swclk_o low for exactly half_i cycles, then high for at least half_i cycles; a half_i of 0 behaves as 1.
- R3: In transmit mode (dir_in_i = 0 at start) swdio_oe_o is 1, bytes are accepted when tx_valid_i and tx_ready_o are both 1, bit 0 of each byte goes out first, and swdio_o holds the bit before the falling edge and across the rising edge.
- R4: A new byte is requested after every 8 transmitted bits; while it is awaited tx_ready_o is 1 and swclk_o stays 1 with no edge.
- R5: In capture mode (dir_in_i = 1 at start) swdio_oe_o is 0 for the whole sequence and swdio_i is sampled in the last system cycle of each low phase.
- R6: Captured bits enter a byte at bit 0 and move up, so in a full byte the first bit received is bit 7.
- R7: After every 8 captured bits rx_data_o is presented with a one-cycle rx_valid_o; when the count ends on a partial byte of m bits, that byte is presented unaligned in bits m-1..0 (first bit at bit m-1) with the upper bits 0.
- R8: The number of swclk_o rising edges in a sequence equals count_i for every count from 1 to 256, whether or not it is a multiple of 8.
- R9: done_o is a one-cycle pulse after the last high phase, with busy_o 0; a count of 0 raises done_o on the cycle after the start edge with no clock edge.
- R10: A start_i pulse while busy_o is 1 is ignored: direction, count and the data of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (ignored while busy) |
| dir_in_i | input | 1 | 1 = capture, 0 = transmit, taken at start |
| count_i | input | 9 | Number of bits, 0 to 256, taken at start |
| half_i | input | 8 | System cycles per clock phase, 0 treated as 1 |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_ready_o | output | 1 | Block accepts a byte this cycle |
| rx_data_o | output | 8 | Captured byte |
| rx_valid_o | output | 1 | rx_data_o holds a new byte for one cycle |
| swclk_o | output | 1 | Port clock, idles high |
| swdio_o | output | 1 | Data line output value |
| swdio_oe_o | output | 1 | Data line driver enable |
| swdio_i | input | 1 | Data line input value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The embedded properties take for granted that half_i stays constant while busy_o is high, that count_i does not exceed 256, and that the byte consumer can take a byte on any cycle because capture has no backpressure. The bench sets half_i only between sequences, uses counts from 0 to 256, and accepts rx_valid_o bytes on every cycle. It drives swdio_i from a pattern indexed by the count of rising edges seen so far, so the bit under test only changes in the high phase and the sampling point in the low phase always sees a settled value.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/dbg_seq_phase_timer.sv
module dbg_seq_phase_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DLY_W-1:0] half_i,
  output logic             last_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] lim;

  assign lim    = (half_i == '0) ? DLY_W'(1) : half_i;
  assign last_o = run_i && (cnt_q == lim - DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || last_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + DLY_W'(1);
  end

  // R2: a phase never outlasts its programmed length
  a_r2_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim));
endmodule

// File: rtl/dbg_seq_tx_shift.sv
module dbg_seq_tx_shift
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              adv_i,
  output logic              dout_o,
  output logic              byte_end_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (adv_i) begin
      sh_q  <= {1'b1, sh_q[BYTE_W-1:1]};
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign dout_o     = sh_q[0];
  assign byte_end_o = (idx_q == IDX_W'(BYTE_W - 1));

  // R3: load and advance never coincide
  a_r3_load_adv_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !adv_i);
endmodule

// File: rtl/dbg_seq_rx_pack.sv
module dbg_seq_rx_pack
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              final_i,
  input  logic              din_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] acc_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] acc_n;
  logic              flush;

  assign acc_n = {acc_q[BYTE_W-2:0], din_i};
  assign flush = sample_i && (final_i || cnt_q == IDX_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (flush) begin
        data_o  <= acc_n;
        valid_o <= 1'b1;
        acc_q   <= '0;
        cnt_q   <= '0;
      end else if (sample_i) begin
        acc_q <= acc_n;
        cnt_q <= cnt_q + IDX_W'(1);
      end
    end
  end

  // R7: each byte is flagged for exactly one cycle
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/dbg_seq_shifter.sv
module dbg_seq_shifter
  import dbg_seq_pkg::*;
#(
  parameter int MAX_BITS = 256,
  parameter int DLY_W    = 8,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_in_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DLY_W-1:0]  half_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] rem_q;
  logic             dir_q;
  logic             oe_q;
  logic             clk_q;
  logic             ph_run, ph_last;
  logic             take;
  logic             byte_end;
  logic             bit_end;

  assign take    = (state_q == ST_IDLE) && start_i;
  assign ph_run  = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign bit_end = (state_q == ST_HIGH) && ph_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  if (count_i == '0)  state_d = ST_DONE;
                  else if (dir_in_i)  state_d = ST_LOW;
                  else                state_d = ST_FETCH;
                end
      ST_FETCH: if (tx_valid_i) state_d = ST_LOW;
      ST_LOW:   if (ph_last) state_d = ST_HIGH;
      ST_HIGH:  if (ph_last) begin
                  if (rem_q == CNT_W'(1))      state_d = ST_DONE;
                  else if (!dir_q && byte_end) state_d = ST_FETCH;
                  else                         state_d = ST_LOW;
                end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      oe_q    <= 1'b0;
      clk_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      clk_q   <= (state_d != ST_LOW);
      if (take) begin
        rem_q <= count_i;
        dir_q <= dir_in_i;
        oe_q  <= !dir_in_i;
      end else if (bit_end) begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  dbg_seq_phase_timer #(.DLY_W(DLY_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ph_run),
    .half_i (half_i),
    .last_o (ph_last)
  );

  dbg_seq_tx_shift u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     ((state_q == ST_FETCH) && tx_valid_i),
    .data_i     (tx_data_i),
    .adv_i      (bit_end && !dir_q),
    .dout_o     (swdio_o),
    .byte_end_o (byte_end)
  );

  dbg_seq_rx_pack u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (take),
    .sample_i ((state_q == ST_LOW) && ph_last && dir_q),
    .final_i  (rem_q == CNT_W'(1)),
    .din_i    (swdio_i),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o)
  );

  assign tx_ready_o = (state_q == ST_FETCH);
  assign swclk_o    = clk_q;
  assign swdio_oe_o = oe_q;
  assign busy_o     = ph_run || (state_q == ST_FETCH);
  assign done_o     = (state_q == ST_DONE);

  // R3: data does not move on a rising clock edge while driving
  a_r3_data_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(swclk_o) && swdio_oe_o) |-> $stable(swdio_o));
  // R4: byte request only while the clock is parked high
  a_r4_ready_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> swclk_o);
  // R5: line released throughout capture
  a_r5_released_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dir_q) |-> !swdio_oe_o);
  // R9: done is a pulse and the clock idles high outside a sequence
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_idle_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> swclk_o);
  // R10: direction is frozen while busy
  a_r10_dir_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dir_q));
endmodule

// File: tb/dbg_seq_shifter_bench.sv
module dbg_seq_shifter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dir_in = 1'b0;
  logic [8:0] count = '0;
  logic [7:0] half = 8'd1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, rx_valid, swclk, swdio, swdio_oe, busy, done;
  logic [7:0] rx_data;
  logic       swdio_in;

  int total = 0, bad = 0, cycles = 0;
  bit txq[$];
  logic [7:0] rxq[$];
  logic [255:0] pat = '0;
  int rise_idx = 0, rises = 0, low_run = 0, exp_low = 1;
  bit mode_tx = 1'b0;
  logic prev_clk = 1'b1;

  always #5 clk = ~clk;

  assign swdio_in = (rise_idx < 256) ? pat[rise_idx[7:0]] : 1'b1;

  dbg_seq_shifter u_dbg_seq_shifter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_in_i(dir_in),
    .count_i(count), .half_i(half), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .swclk_o(swclk), .swdio_o(swdio), .swdio_oe_o(swdio_oe), .swdio_i(swdio_in),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected bits and bytes as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (swclk === 1'b0) low_run++;
      if (prev_clk === 1'b0 && swclk === 1'b1) begin
        rises++;
        chk(low_run == exp_low, "R2 low phase length", low_run, exp_low);
        low_run = 0;
        if (mode_tx) begin
          if (txq.size() == 0) chk(1'b0, "R8 extra rising edge", rises, 0);
          else begin
            bit b;
            b = txq.pop_front();
            chk(swdio === b && swdio_oe === 1'b1, "R3 tx bit at rise", int'(swdio), int'(b));
          end
        end else begin
          chk(swdio_oe === 1'b0, "R5 line released in capture", int'(swdio_oe), 0);
          rise_idx++;
        end
      end
      if (rx_valid === 1'b1) begin
        if (rxq.size() == 0) chk(1'b0, "R7 unexpected rx byte", int'(rx_data), -1);
        else begin
          logic [7:0] e;
          e = rxq.pop_front();
          chk(rx_data === e, "R6 R7 rx byte", int'(rx_data), int'(e));
        end
      end
      if (tx_ready === 1'b1 && tx_valid === 1'b0)
        chk(swclk === 1'b1, "R4 clock parked during fetch", int'(swclk), 1);
      prev_clk = swclk;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_seq(input bit cap, input int n, input int hp, input int stall, input bit poke);
    logic [7:0] bytes [32];
    int nb;
    nb = (n + 7) / 8;
    for (int i = 0; i < 32; i++) bytes[i] = 8'($urandom);
    txq.delete();
    rxq.delete();
    if (!cap) begin
      for (int j = 0; j < n; j++) txq.push_back(bytes[j / 8][j % 8]);
    end else begin
      logic [7:0] acc;
      int k;
      acc = '0;
      k = 0;
      for (int i = 0; i < 8; i++) pat[i*32 +: 32] = $urandom;
      for (int j = 0; j < n; j++) begin
        acc = {acc[6:0], pat[j]};
        k++;
        if (k == 8 || j == n - 1) begin
          rxq.push_back(acc);
          acc = '0;
          k = 0;
        end
      end
    end
    @(negedge clk);
    half = 8'(hp);
    exp_low = (hp == 0) ? 1 : hp;
    mode_tx = !cap;
    rises = 0;
    rise_idx = 0;
    low_run = 0;
    start = 1'b1;
    dir_in = cap;
    count = 9'(n);
    @(negedge clk);
    start = 1'b0;
    if (!cap) begin
      for (int b = 0; b < nb; b++) begin
        repeat (stall) @(negedge clk);
        tx_data = bytes[b];
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
      end
    end else if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;      // R10: must be ignored
      dir_in = 1'b0;
      count = 9'd7;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R9 busy low at done", int'(busy), 0);
    chk(rises == n, "R8 rising edges per sequence", rises, n);
    chk(txq.size() == 0 && rxq.size() == 0, "R8 all items consumed",
        txq.size() + rxq.size(), 0);
    if (poke) chk(rises == n, "R10 start while busy ignored", rises, n);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single pulse", int'(done), 0);
  endtask

  task automatic run_zero(input bit cap);
    @(negedge clk);
    rises = 0;
    start = 1'b1;
    dir_in = cap;
    count = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R9 zero count done next cycle", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && rises == 0, "R9 zero count no edges", rises, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(swclk === 1'b1, "R1 reset swclk", int'(swclk), 1);
    chk({swdio_oe, busy, done, rx_valid, tx_ready} === 5'b0, "R1 reset outputs",
        int'({swdio_oe, busy, done, rx_valid, tx_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(1'b0, 16, 1, 0, 1'b0);
    run_seq(1'b0, 13, 3, 3, 1'b0);
    run_seq(1'b0, 1, 0, 0, 1'b0);
    run_seq(1'b0, 256, 1, 1, 1'b0);
    run_seq(1'b1, 8, 2, 0, 1'b0);
    run_seq(1'b1, 21, 1, 0, 1'b1);
    run_seq(1'b1, 3, 4, 0, 1'b0);
    run_zero(1'b0);
    run_zero(1'b1);
    run_seq(1'b1, 256, 1, 0, 1'b0);
    run_seq(1'b0, 9, 2, 5, 1'b0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule